// File: doc/BRIEF.md
# Synchronous Exception Priority Selector

This block sits beside the trap logic of a processor hart. Every cycle it receives one request line per synchronous exception source and per debug trigger source, and it reports the single cause that wins. The outputs are a valid flag, the exception code and a flag that marks a winner raised by a debug trigger. Trap entry, CSR writes and trigger matching happen in other blocks.

Debug trigger hits have fixed slots among the architectural faults. The highest slots hold the trigger hits that apply before or between instructions, and the lowest slot holds the load-data trigger. A misaligned load or store can be reported in one of two places. In early mode it is reported ahead of address translation. In late mode it is reported only when no translation fault and no physical access fault is pending. Translation faults carry a 2-bit kind so that the fault met first in the walk can be reported. The environment-call code is taken from the current privilege. The block is purely combinational.

Top module: `exc_prio_sel`

## Requirements
- R1: When no request is active, valid_o is 0, cause_o is 0 and trig_o is 0.
- R2: Each of the exception trigger, instruction-count trigger, interrupt trigger and previous-instruction after-match trigger beats every other source. Each reports code 3 with trig_o=1.
- R3: The execute-address breakpoint (code 3, trig_o=1) beats both instruction fetch faults.
- R4: An instruction translation fault reports its code from its kind: 0 page gives 12, 1 guest-page gives 20, and 2 or 3 access gives 1. It beats the physical instruction access fault, which reports code 1.
- R5: The execute-data trigger (code 3, trig_o=1) comes below the fetch faults and above illegal instruction.
- R6: Below the execute-data trigger the order is illegal instruction (2), virtual instruction (22), misaligned instruction address (0), environment call, environment break (3, trig_o=0).
- R7: An environment call reports 8 plus the 2-bit privilege input: 0 gives 8, 1 gives 9, 2 gives 10, 3 gives 11.
- R8: The load/store address-or-data breakpoint (code 3, trig_o=1) sits below environment break and above every data-access fault.
- R9: With misalign_early_i=1, a misaligned access reports 4 for a load or 6 for a store (ls_store_i=1), and it beats data translation faults and physical data access faults.
- R10: With misalign_early_i=0, a misaligned access is reported (4 or 6) only when no data translation fault and no physical data access fault is pending.
- R11: A data translation fault reports, by kind, load/store codes of 13/15 for a page fault (0), 21/23 for a guest-page fault (1) and 5/7 for an access fault (2 or 3). It beats the physical data access fault, which reports 5/7.
- R12: The load-data trigger has the lowest priority and reports code 3 with trig_o=1.
- R13: trig_o is 1 exactly when the winning source is a debug trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| etrig_hit_i | input | 1 | Exception trigger hit |
| icount_hit_i | input | 1 | Instruction-count trigger hit |
| itrig_hit_i | input | 1 | Interrupt trigger hit |
| after_prev_hit_i | input | 1 | After-type match on previous instruction |
| exec_addr_hit_i | input | 1 | Execute-address breakpoint, before |
| if_xlate_flt_i | input | 1 | Instruction translation fault |
| if_xlate_kind_i | input | 2 | Kind of the first instruction translation fault met |
| if_pa_acc_flt_i | input | 1 | Instruction access fault on physical address |
| exec_data_hit_i | input | 1 | Execute-data trigger, before |
| illegal_i | input | 1 | Illegal instruction |
| virt_instr_i | input | 1 | Virtual instruction |
| if_misalign_i | input | 1 | Misaligned instruction address |
| ecall_i | input | 1 | Environment call |
| priv_i | input | 2 | Current privilege for the environment-call code |
| ebreak_i | input | 1 | Environment break |
| ldst_hit_i | input | 1 | Load/store address or data breakpoint, before |
| ls_misalign_i | input | 1 | Misaligned load/store address |
| ls_store_i | input | 1 | 1 means the access is a store or AMO |
| misalign_early_i | input | 1 | 1 reports misaligned accesses before translation |
| ls_xlate_flt_i | input | 1 | Data translation fault |
| ls_xlate_kind_i | input | 2 | Kind of the first data translation fault met |
| ls_pa_acc_flt_i | input | 1 | Data access fault on physical address |
| ld_data_hit_i | input | 1 | Load-data trigger, before completion |
| valid_o | output | 1 | A cause is reported |
| cause_o | output | 6 | Winning exception code |
| trig_o | output | 1 | Winner came from a debug trigger |

## Verification
A wrong link in the priority chain shows up in the same cycle as the wrong code for some pair of requests that are active together. It can be missed if each source is only tested alone. For this reason the scenarios stack many requests and then remove them one at a time from the top. A wrong code table entry or a wrong kind or privilege decode shows up as a wrong cause_o when that source is active alone. A wrong trigger classification shows up on trig_o even when the code is 3 either way, so environment break is tested against the load/store breakpoint. With no state, every fault can be observed at once and is never hidden by history.

// File: rtl/exc_prio_pkg.sv
package exc_prio_pkg;
  localparam int CAUSE_W = 6;
  localparam int KIND_W  = 2;
  localparam int PRIV_W  = 2;

  // sources, listed from highest to lowest priority
  typedef enum logic [4:0] {
    SRC_ETRIG       = 5'd0,
    SRC_ICOUNT      = 5'd1,
    SRC_ITRIG       = 5'd2,
    SRC_AFTER_PREV  = 5'd3,
    SRC_EXEC_ADDR   = 5'd4,
    SRC_IF_XLATE    = 5'd5,
    SRC_IF_PA_ACC   = 5'd6,
    SRC_EXEC_DATA   = 5'd7,
    SRC_ILLEGAL     = 5'd8,
    SRC_VIRT        = 5'd9,
    SRC_IF_MIS      = 5'd10,
    SRC_ECALL       = 5'd11,
    SRC_EBREAK      = 5'd12,
    SRC_LDST_BP     = 5'd13,
    SRC_LS_MIS_ERLY = 5'd14,
    SRC_LS_XLATE    = 5'd15,
    SRC_LS_PA_ACC   = 5'd16,
    SRC_LS_MIS_LATE = 5'd17,
    SRC_LD_DATA     = 5'd18
  } src_e;

  localparam int NUM_SRC = 19;

  typedef enum logic [KIND_W-1:0] {
    XK_PAGE   = 2'd0,
    XK_GUEST  = 2'd1,
    XK_ACCESS = 2'd2,
    XK_RSVD   = 2'd3
  } xlate_kind_e;

  localparam logic [CAUSE_W-1:0] EC_IF_MIS   = 6'd0;
  localparam logic [CAUSE_W-1:0] EC_IF_ACC   = 6'd1;
  localparam logic [CAUSE_W-1:0] EC_ILLEGAL  = 6'd2;
  localparam logic [CAUSE_W-1:0] EC_BREAK    = 6'd3;
  localparam logic [CAUSE_W-1:0] EC_LD_MIS   = 6'd4;
  localparam logic [CAUSE_W-1:0] EC_LD_ACC   = 6'd5;
  localparam logic [CAUSE_W-1:0] EC_ST_MIS   = 6'd6;
  localparam logic [CAUSE_W-1:0] EC_ST_ACC   = 6'd7;
  localparam logic [CAUSE_W-1:0] EC_ECALL_B  = 6'd8;
  localparam logic [CAUSE_W-1:0] EC_IF_PAGE  = 6'd12;
  localparam logic [CAUSE_W-1:0] EC_LD_PAGE  = 6'd13;
  localparam logic [CAUSE_W-1:0] EC_ST_PAGE  = 6'd15;
  localparam logic [CAUSE_W-1:0] EC_IF_GUEST = 6'd20;
  localparam logic [CAUSE_W-1:0] EC_LD_GUEST = 6'd21;
  localparam logic [CAUSE_W-1:0] EC_VIRT     = 6'd22;
  localparam logic [CAUSE_W-1:0] EC_ST_GUEST = 6'd23;

  function automatic logic [CAUSE_W-1:0] if_xlate_code(input logic [KIND_W-1:0] kind);
    case (xlate_kind_e'(kind))
      XK_PAGE:  return EC_IF_PAGE;
      XK_GUEST: return EC_IF_GUEST;
      default:  return EC_IF_ACC;
    endcase
  endfunction

  function automatic logic [CAUSE_W-1:0] ls_xlate_code(input logic [KIND_W-1:0] kind,
                                                       input logic store);
    case (xlate_kind_e'(kind))
      XK_PAGE:  return store ? EC_ST_PAGE  : EC_LD_PAGE;
      XK_GUEST: return store ? EC_ST_GUEST : EC_LD_GUEST;
      default:  return store ? EC_ST_ACC   : EC_LD_ACC;
    endcase
  endfunction
endpackage

// File: rtl/exc_src_map.sv
module exc_src_map
  import exc_prio_pkg::*;
(
  input  logic                  etrig_hit_i,
  input  logic                  icount_hit_i,
  input  logic                  itrig_hit_i,
  input  logic                  after_prev_hit_i,
  input  logic                  exec_addr_hit_i,
  input  logic                  if_xlate_flt_i,
  input  logic [KIND_W-1:0]     if_xlate_kind_i,
  input  logic                  if_pa_acc_flt_i,
  input  logic                  exec_data_hit_i,
  input  logic                  illegal_i,
  input  logic                  virt_instr_i,
  input  logic                  if_misalign_i,
  input  logic                  ecall_i,
  input  logic [PRIV_W-1:0]     priv_i,
  input  logic                  ebreak_i,
  input  logic                  ldst_hit_i,
  input  logic                  ls_misalign_i,
  input  logic                  ls_store_i,
  input  logic                  misalign_early_i,
  input  logic                  ls_xlate_flt_i,
  input  logic [KIND_W-1:0]     ls_xlate_kind_i,
  input  logic                  ls_pa_acc_flt_i,
  input  logic                  ld_data_hit_i,
  output logic [NUM_SRC-1:0]    req_o,
  output logic [NUM_SRC-1:0][CAUSE_W:0] pay_o
);
  logic [NUM_SRC-1:0]              req;
  logic [NUM_SRC-1:0][CAUSE_W-1:0] code;
  logic [NUM_SRC-1:0]              is_trig;
  logic [CAUSE_W-1:0]              ls_mis_code;

  assign ls_mis_code = ls_store_i ? EC_ST_MIS : EC_LD_MIS;

  always_comb begin
    req     = '0;
    code    = '0;
    is_trig = '0;

    req[SRC_ETRIG]       = etrig_hit_i;
    req[SRC_ICOUNT]      = icount_hit_i;
    req[SRC_ITRIG]       = itrig_hit_i;
    req[SRC_AFTER_PREV]  = after_prev_hit_i;
    req[SRC_EXEC_ADDR]   = exec_addr_hit_i;
    req[SRC_IF_XLATE]    = if_xlate_flt_i;
    req[SRC_IF_PA_ACC]   = if_pa_acc_flt_i;
    req[SRC_EXEC_DATA]   = exec_data_hit_i;
    req[SRC_ILLEGAL]     = illegal_i;
    req[SRC_VIRT]        = virt_instr_i;
    req[SRC_IF_MIS]      = if_misalign_i;
    req[SRC_ECALL]       = ecall_i;
    req[SRC_EBREAK]      = ebreak_i;
    req[SRC_LDST_BP]     = ldst_hit_i;
    req[SRC_LS_MIS_ERLY] = ls_misalign_i & misalign_early_i;
    req[SRC_LS_XLATE]    = ls_xlate_flt_i;
    req[SRC_LS_PA_ACC]   = ls_pa_acc_flt_i;
    req[SRC_LS_MIS_LATE] = ls_misalign_i & ~misalign_early_i;
    req[SRC_LD_DATA]     = ld_data_hit_i;

    code[SRC_ETRIG]       = EC_BREAK;
    code[SRC_ICOUNT]      = EC_BREAK;
    code[SRC_ITRIG]       = EC_BREAK;
    code[SRC_AFTER_PREV]  = EC_BREAK;
    code[SRC_EXEC_ADDR]   = EC_BREAK;
    code[SRC_IF_XLATE]    = if_xlate_code(if_xlate_kind_i);
    code[SRC_IF_PA_ACC]   = EC_IF_ACC;
    code[SRC_EXEC_DATA]   = EC_BREAK;
    code[SRC_ILLEGAL]     = EC_ILLEGAL;
    code[SRC_VIRT]        = EC_VIRT;
    code[SRC_IF_MIS]      = EC_IF_MIS;
    code[SRC_ECALL]       = EC_ECALL_B | CAUSE_W'(priv_i);
    code[SRC_EBREAK]      = EC_BREAK;
    code[SRC_LDST_BP]     = EC_BREAK;
    code[SRC_LS_MIS_ERLY] = ls_mis_code;
    code[SRC_LS_XLATE]    = ls_xlate_code(ls_xlate_kind_i, ls_store_i);
    code[SRC_LS_PA_ACC]   = ls_store_i ? EC_ST_ACC : EC_LD_ACC;
    code[SRC_LS_MIS_LATE] = ls_mis_code;
    code[SRC_LD_DATA]     = EC_BREAK;

    is_trig[SRC_ETRIG]      = 1'b1;
    is_trig[SRC_ICOUNT]     = 1'b1;
    is_trig[SRC_ITRIG]      = 1'b1;
    is_trig[SRC_AFTER_PREV] = 1'b1;
    is_trig[SRC_EXEC_ADDR]  = 1'b1;
    is_trig[SRC_EXEC_DATA]  = 1'b1;
    is_trig[SRC_LDST_BP]    = 1'b1;
    is_trig[SRC_LD_DATA]    = 1'b1;
  end

  assign req_o = req;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pay
    assign pay_o[g] = {is_trig[g], code[g]};
  end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 4,
  parameter int W = 4
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0][W-1:0] pay_i,
  output logic [N-1:0]        grant_o,
  output logic                any_o,
  output logic [W-1:0]        pay_o
);
  // blocked[i]: some lower index (higher priority) is requesting
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign blocked[g+1] = blocked[g] | req_i[g];
    assign grant_o[g]   = req_i[g] & ~blocked[g];
  end

  assign any_o = blocked[N];

  always_comb begin
    pay_o = '0;
    for (int i = 0; i < N; i++) begin
      pay_o = pay_o | (pay_i[i] & {W{grant_o[i]}});
    end
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_prio_pkg::*;
(
  input  logic               etrig_hit_i,
  input  logic               icount_hit_i,
  input  logic               itrig_hit_i,
  input  logic               after_prev_hit_i,
  input  logic               exec_addr_hit_i,
  input  logic               if_xlate_flt_i,
  input  logic [1:0]         if_xlate_kind_i,
  input  logic               if_pa_acc_flt_i,
  input  logic               exec_data_hit_i,
  input  logic               illegal_i,
  input  logic               virt_instr_i,
  input  logic               if_misalign_i,
  input  logic               ecall_i,
  input  logic [1:0]         priv_i,
  input  logic               ebreak_i,
  input  logic               ldst_hit_i,
  input  logic               ls_misalign_i,
  input  logic               ls_store_i,
  input  logic               misalign_early_i,
  input  logic               ls_xlate_flt_i,
  input  logic [1:0]         ls_xlate_kind_i,
  input  logic               ls_pa_acc_flt_i,
  input  logic               ld_data_hit_i,
  output logic               valid_o,
  output logic [5:0]         cause_o,
  output logic               trig_o
);
  logic [NUM_SRC-1:0]              req;
  logic [NUM_SRC-1:0][CAUSE_W:0]   pay;
  logic [NUM_SRC-1:0]              grant;
  logic [CAUSE_W:0]                win;

  exc_src_map u_map (
    .etrig_hit_i      (etrig_hit_i),
    .icount_hit_i     (icount_hit_i),
    .itrig_hit_i      (itrig_hit_i),
    .after_prev_hit_i (after_prev_hit_i),
    .exec_addr_hit_i  (exec_addr_hit_i),
    .if_xlate_flt_i   (if_xlate_flt_i),
    .if_xlate_kind_i  (if_xlate_kind_i),
    .if_pa_acc_flt_i  (if_pa_acc_flt_i),
    .exec_data_hit_i  (exec_data_hit_i),
    .illegal_i        (illegal_i),
    .virt_instr_i     (virt_instr_i),
    .if_misalign_i    (if_misalign_i),
    .ecall_i          (ecall_i),
    .priv_i           (priv_i),
    .ebreak_i         (ebreak_i),
    .ldst_hit_i       (ldst_hit_i),
    .ls_misalign_i    (ls_misalign_i),
    .ls_store_i       (ls_store_i),
    .misalign_early_i (misalign_early_i),
    .ls_xlate_flt_i   (ls_xlate_flt_i),
    .ls_xlate_kind_i  (ls_xlate_kind_i),
    .ls_pa_acc_flt_i  (ls_pa_acc_flt_i),
    .ld_data_hit_i    (ld_data_hit_i),
    .req_o            (req),
    .pay_o            (pay)
  );

  exc_prio_pick #(.N(NUM_SRC), .W(CAUSE_W + 1)) u_pick (
    .req_i   (req),
    .pay_i   (pay),
    .grant_o (grant),
    .any_o   (valid_o),
    .pay_o   (win)
  );

  assign cause_o = win[CAUSE_W-1:0];
  assign trig_o  = win[CAUSE_W];
endmodule

// File: rtl/exc_prio_chk.sv
module exc_prio_chk
  import exc_prio_pkg::*;
(
  input logic                etrig_hit_i,
  input logic                icount_hit_i,
  input logic                itrig_hit_i,
  input logic                after_prev_hit_i,
  input logic                ecall_i,
  input logic [1:0]          priv_i,
  input logic                ld_data_hit_i,
  input logic                valid_o,
  input logic [5:0]          cause_o,
  input logic                trig_o,
  input logic [NUM_SRC-1:0]  grant
);
  always_comb begin
    // R1
    if (!valid_o) a_r1_idle_zero: assert (cause_o == '0 && !trig_o);
    // R2
    if (etrig_hit_i || icount_hit_i || itrig_hit_i || after_prev_hit_i)
      a_r2_top_trig: assert (valid_o && cause_o == EC_BREAK && trig_o);
    // R13
    if (trig_o) a_r13_trig_code: assert (valid_o && cause_o == EC_BREAK);
    // R7
    if (grant[SRC_ECALL])
      a_r7_ecall_code: assert (cause_o == (EC_ECALL_B | 6'(priv_i)) && !trig_o);
    // R12
    if (ld_data_hit_i) a_r12_ld_data_valid: assert (valid_o);
    a_r13_grant_one: assert ($onehot0(grant) && (valid_o == (grant != '0)));
  end
endmodule

bind exc_prio_sel exc_prio_chk u_chk (.*);

// File: tb/tb_exc_prio_sel.sv
module tb_exc_prio_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic etrig, icount, itrig, after_prev, exec_addr, if_xf, if_pa, exec_data;
  logic illegal, virt, if_mis, ecall, ebreak, ldst_bp, ls_mis, ls_st, early;
  logic ls_xf, ls_pa, ld_data;
  logic [1:0] if_kind, priv, ls_kind;
  logic       valid;
  logic [5:0] cause;
  logic       trig;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  exc_prio_sel dut (
    .etrig_hit_i(etrig), .icount_hit_i(icount), .itrig_hit_i(itrig),
    .after_prev_hit_i(after_prev), .exec_addr_hit_i(exec_addr),
    .if_xlate_flt_i(if_xf), .if_xlate_kind_i(if_kind), .if_pa_acc_flt_i(if_pa),
    .exec_data_hit_i(exec_data), .illegal_i(illegal), .virt_instr_i(virt),
    .if_misalign_i(if_mis), .ecall_i(ecall), .priv_i(priv), .ebreak_i(ebreak),
    .ldst_hit_i(ldst_bp), .ls_misalign_i(ls_mis), .ls_store_i(ls_st),
    .misalign_early_i(early), .ls_xlate_flt_i(ls_xf), .ls_xlate_kind_i(ls_kind),
    .ls_pa_acc_flt_i(ls_pa), .ld_data_hit_i(ld_data),
    .valid_o(valid), .cause_o(cause), .trig_o(trig)
  );

  task automatic clear_all();
    {etrig, icount, itrig, after_prev, exec_addr, if_xf, if_pa, exec_data} = '0;
    {illegal, virt, if_mis, ecall, ebreak, ldst_bp, ls_mis, ls_st, early} = '0;
    {ls_xf, ls_pa, ld_data} = '0;
    if_kind = 2'd0; priv = 2'd0; ls_kind = 2'd0;
  endtask

  task automatic check(input string rq, input logic ev, input logic [5:0] ec, input logic et);
    @(negedge clk);
    n_tests++;
    if (valid !== ev || cause !== ec || trig !== et) begin
      n_fail++;
      $display("FAIL %s: got v=%0b c=%0d t=%0b exp v=%0b c=%0d t=%0b",
               rq, valid, cause, trig, ev, ec, et);
    end
  endtask

  task automatic t_idle();
    clear_all();
    check("R1 idle", 1'b0, 6'd0, 1'b0);
    priv = 2'd3; ls_st = 1'b1; early = 1'b1; if_kind = 2'd1; ls_kind = 2'd1;
    check("R1 idle cfg only", 1'b0, 6'd0, 1'b0);
  endtask

  task automatic set_all_low_faults();
    exec_addr = 1; if_xf = 1; if_pa = 1; exec_data = 1; illegal = 1; virt = 1;
    if_mis = 1; ecall = 1; ebreak = 1; ldst_bp = 1; ls_mis = 1; ls_xf = 1;
    ls_pa = 1; ld_data = 1;
  endtask

  task automatic t_top_triggers();
    for (int i = 0; i < 4; i++) begin
      clear_all();
      set_all_low_faults();
      case (i)
        0: etrig = 1;
        1: icount = 1;
        2: itrig = 1;
        default: after_prev = 1;
      endcase
      check("R2 top trigger", 1'b1, 6'd3, 1'b1);
    end
  endtask

  task automatic t_fetch();
    clear_all();
    exec_addr = 1; if_xf = 1; if_pa = 1; illegal = 1;
    check("R3 exec addr bp", 1'b1, 6'd3, 1'b1);
    exec_addr = 0;
    if_kind = 2'd0; check("R4 if page", 1'b1, 6'd12, 1'b0);
    if_kind = 2'd1; check("R4 if guest", 1'b1, 6'd20, 1'b0);
    if_kind = 2'd2; check("R4 if access", 1'b1, 6'd1, 1'b0);
    if_kind = 2'd3; check("R4 if kind3", 1'b1, 6'd1, 1'b0);
    if_xf = 0;
    check("R4 if pa fault", 1'b1, 6'd1, 1'b0);
  endtask

  task automatic t_exec_group();
    clear_all();
    exec_data = 1; illegal = 1; virt = 1; if_mis = 1; ecall = 1; ebreak = 1;
    priv = 2'd3; ldst_bp = 1;
    check("R5 exec data", 1'b1, 6'd3, 1'b1);
    exec_data = 0; check("R6 illegal", 1'b1, 6'd2, 1'b0);
    illegal = 0;   check("R6 virtual", 1'b1, 6'd22, 1'b0);
    virt = 0;      check("R6 if misalign", 1'b1, 6'd0, 1'b0);
    if_mis = 0;    check("R6 ecall", 1'b1, 6'd11, 1'b0);
    ecall = 0;     check("R6 R13 ebreak over ldst bp", 1'b1, 6'd3, 1'b0);
    clear_all(); exec_data = 1; if_pa = 1;
    check("R5 below fetch fault", 1'b1, 6'd1, 1'b0);
  endtask

  task automatic t_ecall_priv();
    clear_all();
    ecall = 1; ebreak = 1;
    for (int p = 0; p < 4; p++) begin
      priv = 2'(p);
      check("R7 ecall priv", 1'b1, 6'(8 + p), 1'b0);
    end
  endtask

  task automatic t_data_bp();
    clear_all();
    ldst_bp = 1; ls_mis = 1; early = 1; ls_xf = 1; ls_pa = 1; ld_data = 1; ls_st = 1;
    check("R8 ldst bp", 1'b1, 6'd3, 1'b1);
  endtask

  task automatic t_misalign();
    clear_all();
    early = 1; ls_mis = 1; ls_xf = 1; ls_pa = 1;
    check("R9 early load", 1'b1, 6'd4, 1'b0);
    ls_st = 1; check("R9 early store", 1'b1, 6'd6, 1'b0);
    early = 0; ls_st = 0;
    check("R10 late under xlate", 1'b1, 6'd13, 1'b0);
    ls_xf = 0; ls_st = 1;
    check("R10 late under pa", 1'b1, 6'd7, 1'b0);
    ls_pa = 0; check("R10 late store alone", 1'b1, 6'd6, 1'b0);
    ls_st = 0; ld_data = 1;
    check("R10 late load over ld data", 1'b1, 6'd4, 1'b0);
  endtask

  task automatic t_data_xlate();
    logic [5:0] exp_ld [4] = '{6'd13, 6'd21, 6'd5, 6'd5};
    logic [5:0] exp_st [4] = '{6'd15, 6'd23, 6'd7, 6'd7};
    clear_all();
    ls_xf = 1; ls_pa = 1;
    for (int k = 0; k < 4; k++) begin
      ls_kind = 2'(k);
      ls_st = 0; check("R11 ld xlate", 1'b1, exp_ld[k], 1'b0);
      ls_st = 1; check("R11 st xlate", 1'b1, exp_st[k], 1'b0);
    end
    ls_xf = 0; ls_st = 0;
    check("R11 ld pa", 1'b1, 6'd5, 1'b0);
  endtask

  task automatic t_lowest();
    clear_all();
    ld_data = 1; ls_pa = 1; ls_st = 1;
    check("R12 below pa", 1'b1, 6'd7, 1'b0);
    ls_pa = 0;
    check("R12 R13 ld data alone", 1'b1, 6'd3, 1'b1);
  endtask

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_top_triggers();
    t_fetch();
    t_exec_group();
    t_ecall_priv();
    t_data_bp();
    t_misalign();
    t_data_xlate();
    t_lowest();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got cycles=%0d exp below 20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule